// File: doc/BRIEF.md
# Multidrop Serial Transceiver

This block is a full-duplex asynchronous serial transceiver. It drives one transmit line, samples one receive line, and is set up through a small register bus. The bit rate comes from a 16-bit divisor that feeds a sixteen-times oversampling tick. The character format can be changed: 5 to 8 data bits, none, even or odd parity, and one or two stop bits. A holding register sits in front of the shift register in each direction, so software has a full character time to supply or collect the next byte.

For shared multidrop lines there is a nine-bit mode. A ninth data bit goes out after the eight ordinary bits and marks the character as an address. On receive, the block waits for an address character that equals its programmed node number. Until that arrives it drops all data characters. Once it matches, it delivers that address and the data that follows. It goes back to waiting when another node's address appears.

Top module: `mdu_uart`

Register map (bus_addr): 0 data (write: transmit holding, read: receive holding and mark it read), 1 line format, 2 divisor, 3 interrupt mask, 4 status (read clears the three error flags), 5 node number.
Line format bits: [1:0] data length minus 5, [2] two stop bits, [3] parity on, [4] odd parity, [5] nine-bit mode (a write to this register arms the address wait).
Status bits: [0] receive data ready, [1] transmit holding empty, [2] transmitter idle, [3] parity error, [4] framing error, [5] overrun.

## Requirements
- R1: After reset, tx_o is high, status reads 0x06 (holding empty, transmitter idle), and both interrupt outputs are low.
- R2: One bit lasts 16*(divisor+1) clock cycles. A divisor of 0 gives 16 clocks per bit.
- R3: A transmitted frame is one low start bit, then the data bits least significant first. The count of data bits is the line format field [1:0] plus 5.
- R4: With line format bit 3 set, one parity bit follows the data bits. It makes the count of ones even, or odd when bit 4 is set. With bit 3 clear, no parity bit is sent.
- R5: The frame ends with one high stop bit, or two when line format bit 2 is set.
- R6: A character written while the transmitter is busy waits in the holding register. Status bit 1 reads 0 during the wait. It starts immediately after the last stop bit of the frame in progress, with no idle gap. With nothing waiting, the line returns to high and idle.
- R7: A received character with a valid start bit is placed in the receive holding register, right-justified, and sets status bit 0. Reading register 0 returns it and clears bit 0.
- R8: The receiver sets status bit 3 when the received parity bit does not match the parity computed over the data, and status bit 4 when the first stop bit samples low. Both flags stay set until status is read.
- R9: A character that completes while the receive holding register is still unread is discarded. It sets status bit 5, and the held character is left unchanged.
- R10: In nine-bit mode (line format bit 5), the transmitter sends nine data bits. Bit 8 of the written word goes out last, and the length field is ignored.
- R11: In nine-bit mode the receiver drops characters while waiting for its address. It accepts a character with bit 8 set whose low eight bits equal the node number, returns it as read data with bit 8 set, and then accepts data characters. An address for another node sends it back to waiting.
- R12: irq_tx is high exactly when mask bit 0 is set and the transmit holding register is empty. irq_rx is high exactly when mask bit 1 is set and received data is ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid during the strobe |
| tx_o | output | 1 | Serial transmit line, idles high |
| rx_i | input | 1 | Serial receive line |
| irq_tx | output | 1 | Transmit holding empty interrupt |
| irq_rx | output | 1 | Receive data ready interrupt |

## Verification
The embedded properties rely on four input conditions. The line format, divisor and node number do not change while a frame is in flight. The receive line holds each bit for a whole bit period. Access strobes last one cycle. A register read and a write never come in the same cycle. The bench meets these conditions by changing configuration only when both directions are idle. It also drives every received bit for exactly the bit period the divisor defines, and issues each register access as a single-cycle strobe from its own task.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  localparam int DATA_W = 9;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } frame_st_e;

  // Bit positions match the line format register layout.
  typedef struct packed {
    logic       nine;
    logic       par_odd;
    logic       par_en;
    logic       stop2;
    logic [1:0] len;
  } line_cfg_t;

  localparam int CFG_W = $bits(line_cfg_t);

  localparam logic [2:0] RA_DATA = 3'd0;
  localparam logic [2:0] RA_LINE = 3'd1;
  localparam logic [2:0] RA_DIV  = 3'd2;
  localparam logic [2:0] RA_MASK = 3'd3;
  localparam logic [2:0] RA_STAT = 3'd4;
  localparam logic [2:0] RA_NODE = 3'd5;

  // Number of data bits carried by one character.
  function automatic logic [3:0] char_bits(input line_cfg_t c);
    return c.nine ? 4'd9 : (4'd5 + {2'b00, c.len});
  endfunction

  // Mask selecting the valid data bits of a character.
  function automatic logic [DATA_W-1:0] char_mask(input line_cfg_t c);
    return {DATA_W{1'b1}} >> (4'd9 - char_bits(c));
  endfunction

  // Parity bit value to send (or expect) for a character.
  function automatic logic parity_of(input logic [DATA_W-1:0] d, input line_cfg_t c);
    return (^(d & char_mask(c))) ^ c.par_odd;
  endfunction

endpackage

// File: rtl/mdu_baud.sv
module mdu_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R2
  tick_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (div != '0)) |=> (!tick || (div == '0)));

endmodule

// File: rtl/mdu_tx.sv
module mdu_tx
  import mdu_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  line_cfg_t     cfg,
  input  logic          hold_full,
  input  logic [DW-1:0] hold_data,
  output logic          take,
  output logic          txd,
  output logic          busy
);

  frame_st_e     st;
  logic [3:0]    tcnt;
  logic [3:0]    bidx;
  logic [DW-1:0] shr;
  logic          par_q;
  logic          stop_more;
  line_cfg_t     cfg_q;

  logic bit_end;
  logic last_stop;

  assign bit_end   = tick && (tcnt == 4'd15);
  assign last_stop = (st == S_STOP) && bit_end && !stop_more;
  assign take      = hold_full && ((st == S_IDLE) || last_stop);
  assign busy      = (st != S_IDLE);

  always_comb begin
    case (st)
      S_START: txd = 1'b0;
      S_DATA:  txd = shr[0];
      S_PAR:   txd = par_q;
      default: txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tcnt      <= '0;
      bidx      <= '0;
      shr       <= '0;
      par_q     <= 1'b0;
      stop_more <= 1'b0;
      cfg_q     <= '0;
    end else begin
      if ((st != S_IDLE) && tick) tcnt <= tcnt + 1'b1;
      if (take) begin
        st    <= S_START;
        tcnt  <= '0;
        shr   <= hold_data & char_mask(cfg);
        par_q <= parity_of(hold_data, cfg);
        cfg_q <= cfg;
      end else if (bit_end) begin
        case (st)
          S_START: begin
            st   <= S_DATA;
            bidx <= '0;
          end
          S_DATA: begin
            shr <= shr >> 1;
            if (bidx == char_bits(cfg_q) - 4'd1) begin
              st        <= cfg_q.par_en ? S_PAR : S_STOP;
              stop_more <= cfg_q.stop2;
            end else begin
              bidx <= bidx + 1'b1;
            end
          end
          S_PAR: begin
            st        <= S_STOP;
            stop_more <= cfg_q.stop2;
          end
          S_STOP: begin
            if (stop_more) stop_more <= 1'b0;
            else           st        <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ((st == S_START) && !txd));

  // R6
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_stop && !hold_full) |=> (txd && !busy));

endmodule

// File: rtl/mdu_rx.sv
module mdu_rx
  import mdu_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  line_cfg_t     cfg,
  input  logic          rxd,
  input  logic [7:0]    node,
  input  logic          rearm,
  output logic          fr_end,
  output logic          fr_acc,
  output logic [DW-1:0] fr_data,
  output logic          fr_pe,
  output logic          fr_fe
);

  logic [2:0]    sync;
  logic          rx_s;
  logic          rx_prev;
  frame_st_e     st;
  logic [3:0]    tcnt;
  logic [3:0]    bidx;
  logic [DW-1:0] shr;
  logic          par_rx;
  line_cfg_t     cfg_q;
  logic          waiting;

  logic mid_start;
  logic sample;
  logic is_addr;
  logic addr_hit;
  logic accept;

  assign rx_s      = sync[1];
  assign rx_prev   = sync[2];
  assign mid_start = tick && (tcnt == 4'd7);
  assign sample    = tick && (tcnt == 4'd15);
  assign is_addr   = cfg_q.nine && shr[8];
  assign addr_hit  = (shr[7:0] == node);
  assign accept    = !cfg_q.nine ? 1'b1 : (is_addr ? addr_hit : !waiting);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 3'b111;
    else        sync <= {sync[1:0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tcnt    <= '0;
      bidx    <= '0;
      shr     <= '0;
      par_rx  <= 1'b0;
      cfg_q   <= '0;
      waiting <= 1'b1;
      fr_end  <= 1'b0;
      fr_acc  <= 1'b0;
      fr_data <= '0;
      fr_pe   <= 1'b0;
      fr_fe   <= 1'b0;
    end else begin
      fr_end <= 1'b0;
      fr_acc <= 1'b0;
      if (rearm) waiting <= 1'b1;
      if ((st != S_IDLE) && tick) tcnt <= tcnt + 1'b1;
      case (st)
        S_IDLE: begin
          if (rx_prev && !rx_s) begin
            st    <= S_START;
            tcnt  <= '0;
            cfg_q <= cfg;
          end
        end
        S_START: begin
          if (mid_start) begin
            if (!rx_s) begin
              st   <= S_DATA;
              tcnt <= '0;
              bidx <= '0;
              shr  <= '0;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        S_DATA: begin
          if (sample) begin
            shr[bidx] <= rx_s;
            if (bidx == char_bits(cfg_q) - 4'd1) st <= cfg_q.par_en ? S_PAR : S_STOP;
            else                                  bidx <= bidx + 1'b1;
          end
        end
        S_PAR: begin
          if (sample) begin
            par_rx <= rx_s;
            st     <= S_STOP;
          end
        end
        S_STOP: begin
          if (sample) begin
            st      <= S_IDLE;
            fr_end  <= 1'b1;
            fr_fe   <= !rx_s;
            fr_pe   <= cfg_q.par_en && (par_rx != parity_of(shr, cfg_q));
            fr_data <= shr;
            fr_acc  <= accept;
            if (is_addr) waiting <= !addr_hit;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8
  stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && (st == S_STOP) && !rx_s) |=> (fr_end && fr_fe));

  // R11
  addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_acc && cfg_q.nine && fr_data[8]) |-> (fr_data[7:0] == node));

endmodule

// File: rtl/mdu_uart.sv
module mdu_uart
  import mdu_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             tx_o,
  input  logic             rx_i,
  output logic             irq_tx,
  output logic             irq_rx
);

  line_cfg_t         line_q;
  logic [DIV_W-1:0]  div_q;
  logic [1:0]        mask_q;
  logic [7:0]        node_q;
  logic [DATA_W-1:0] thr;
  logic              thr_full;
  logic [DATA_W-1:0] rbr;
  logic              rbr_full;
  logic              pe_q;
  logic              fe_q;
  logic              ovr_q;

  logic              tick;
  logic              tx_take;
  logic              tx_busy;
  logic              fr_end;
  logic              fr_acc;
  logic [DATA_W-1:0] fr_data;
  logic              fr_pe;
  logic              fr_fe;

  logic wr_any;
  logic rd_any;
  logic wr_data;
  logic wr_line;
  logic wr_mask;
  logic rd_data;
  logic rd_stat;
  logic [5:0] stat_vec;

  assign wr_any  = bus_sel && bus_wr;
  assign rd_any  = bus_sel && !bus_wr;
  assign wr_data = wr_any && (bus_addr == RA_DATA);
  assign wr_line = wr_any && (bus_addr == RA_LINE);
  assign wr_mask = wr_any && (bus_addr == RA_MASK);
  assign rd_data = rd_any && (bus_addr == RA_DATA);
  assign rd_stat = rd_any && (bus_addr == RA_STAT);

  assign stat_vec = {ovr_q, fe_q, pe_q, !tx_busy, !thr_full, rbr_full};

  mdu_baud #(.DIV_W(DIV_W)) u_baud (
    .clk   (clk),
    .rst_n (rst_n),
    .div   (div_q),
    .tick  (tick)
  );

  mdu_tx #(.DW(DATA_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cfg       (line_q),
    .hold_full (thr_full),
    .hold_data (thr),
    .take      (tx_take),
    .txd       (tx_o),
    .busy      (tx_busy)
  );

  mdu_rx #(.DW(DATA_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .cfg     (line_q),
    .rxd     (rx_i),
    .node    (node_q),
    .rearm   (wr_line),
    .fr_end  (fr_end),
    .fr_acc  (fr_acc),
    .fr_data (fr_data),
    .fr_pe   (fr_pe),
    .fr_fe   (fr_fe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      div_q  <= '0;
      mask_q <= '0;
      node_q <= '0;
    end else if (wr_any) begin
      case (bus_addr)
        RA_LINE: line_q <= bus_wdata[CFG_W-1:0];
        RA_DIV:  div_q  <= bus_wdata[DIV_W-1:0];
        RA_MASK: mask_q <= bus_wdata[1:0];
        RA_NODE: node_q <= bus_wdata[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr      <= '0;
      thr_full <= 1'b0;
    end else if (wr_data) begin
      thr      <= bus_wdata[DATA_W-1:0];
      thr_full <= 1'b1;
    end else if (tx_take) begin
      thr_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbr      <= '0;
      rbr_full <= 1'b0;
      ovr_q    <= 1'b0;
      pe_q     <= 1'b0;
      fe_q     <= 1'b0;
    end else begin
      if (fr_acc && (!rbr_full || rd_data)) begin
        rbr      <= fr_data;
        rbr_full <= 1'b1;
      end else if (rd_data) begin
        rbr_full <= 1'b0;
      end
      if (fr_acc && rbr_full && !rd_data) ovr_q <= 1'b1;
      else if (rd_stat)                   ovr_q <= 1'b0;
      if (fr_end && fr_pe) pe_q <= 1'b1;
      else if (rd_stat)    pe_q <= 1'b0;
      if (fr_end && fr_fe) fe_q <= 1'b1;
      else if (rd_stat)    fe_q <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      RA_DATA: bus_rdata = BUS_W'(rbr);
      RA_LINE: bus_rdata = BUS_W'(line_q);
      RA_DIV:  bus_rdata = BUS_W'(div_q);
      RA_MASK: bus_rdata = BUS_W'(mask_q);
      RA_STAT: bus_rdata = BUS_W'(stat_vec);
      RA_NODE: bus_rdata = BUS_W'(node_q);
      default: bus_rdata = '0;
    endcase
  end

  assign irq_tx = mask_q[0] && !thr_full;
  assign irq_rx = mask_q[1] && rbr_full;

  // R9
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_acc && rbr_full && !rd_data) |=> (ovr_q && $stable(rbr)));

  // R7
  rbr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rbr_full) |-> $past(fr_acc));

  // R12
  irq_tx_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_tx) |-> $past(wr_data || wr_mask));

endmodule

// File: tb/tb_mdu_uart.sv
module tb_mdu_uart;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        tx_o;
  logic        rx_line;
  logic        irq_tx;
  logic        irq_rx;

  always #2 clk = ~clk;

  mdu_uart dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tx_o      (tx_o),
    .rx_i      (rx_line),
    .irq_tx    (irq_tx),
    .irq_rx    (irq_rx)
  );

  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  int bitc = 48;
  int mon_done = 0;
  int pushed = 0;
  int last_gap = 0;
  logic [15:0] exp_bits[$];
  int          exp_len[$];

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // Scoreboard driver: build the expected line sequence and queue it.
  task automatic push_tx(input logic [8:0] d, input int nb, input bit pen, input bit podd,
                         input int nstop);
    logic [15:0] b;
    int          n;
    logic        p;
    b = '0; n = 1; p = podd;
    for (int i = 0; i < nb; i++) begin
      b[n] = d[i]; p = p ^ d[i]; n++;
    end
    if (pen) begin b[n] = p; n++; end
    for (int i = 0; i < nstop; i++) begin b[n] = 1'b1; n++; end
    exp_bits.push_back(b);
    exp_len.push_back(n);
    pushed++;
    bus_write(3'd0, {7'd0, d});
  endtask

  task automatic wait_tx();
    while (mon_done != pushed) @(negedge clk);
    repeat (bitc) @(negedge clk);
  endtask

  task automatic send_rx(input logic [8:0] d, input int nb, input bit pen, input bit podd,
                         input bit bad_par, input bit bad_stop);
    logic p;
    p = podd;
    for (int i = 0; i < nb; i++) p = p ^ d[i];
    if (bad_par) p = ~p;
    @(negedge clk);
    rx_line = 1'b0;
    repeat (bitc) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rx_line = d[i];
      repeat (bitc) @(negedge clk);
    end
    if (pen) begin
      rx_line = p;
      repeat (bitc) @(negedge clk);
    end
    rx_line = bad_stop ? 1'b0 : 1'b1;
    repeat (bitc) @(negedge clk);
    rx_line = 1'b1;
    repeat (bitc) @(negedge clk);
  endtask

  // Scoreboard monitor: decode tx_o and compare against the queue.
  initial begin : tx_mon
    logic [15:0] got;
    logic [15:0] want;
    int          len;
    int          t0;
    int          prev_t0;
    prev_t0 = 0;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && tx_o === 1'b0) begin
        t0 = cyc; last_gap = t0 - prev_t0; prev_t0 = t0;
        got = '0;
        if (exp_len.size() == 0) begin
          check(1'b0, "R3 unexpected tx frame", 0, 0);
          want = '0; len = 1;
        end else begin
          want = exp_bits.pop_front();
          len  = exp_len.pop_front();
        end
        repeat (bitc / 2) @(negedge clk);
        got[0] = tx_o;
        for (int i = 1; i < len; i++) begin
          repeat (bitc) @(negedge clk);
          got[i] = tx_o;
        end
        check(got == want, "R3 R4 R5 R10 tx frame", int'(got), int'(want));
        mon_done++;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [15:0] rd;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; rx_line = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(tx_o == 1'b1, "R1 tx idle high", int'(tx_o), 1);
    bus_read(3'd4, rd);
    check(rd == 16'h0006, "R1 reset status", int'(rd), 16'h0006);
    check(!irq_tx && !irq_rx, "R1 irqs low", int'({irq_tx, irq_rx}), 0);

    bus_write(3'd2, 16'd2); bitc = 48;

    // R3 8 data bits, no parity, one stop
    bus_write(3'd1, 16'h0003);
    push_tx(9'h0A5, 8, 0, 0, 1);
    wait_tx();
    bus_read(3'd4, rd);
    check((rd & 16'h0006) == 16'h0006, "R6 idle after frame", int'(rd), 6);

    // R4 R5 five bits, even parity, two stops
    bus_write(3'd1, 16'h000C);
    push_tx(9'h013, 5, 1, 0, 2);
    wait_tx();

    // R4 seven bits, odd parity
    bus_write(3'd1, 16'h001A);
    push_tx(9'h05A, 7, 1, 1, 1);
    wait_tx();

    // R6 back-to-back characters
    bus_write(3'd1, 16'h0003);
    push_tx(9'h011, 8, 0, 0, 1);
    push_tx(9'h022, 8, 0, 0, 1);
    bus_read(3'd4, rd);
    check((rd & 16'h0002) == 0, "R6 holding busy", int'(rd & 16'h0002), 0);
    wait_tx();
    check(last_gap <= 480 && last_gap >= 477, "R2 R6 no gap", last_gap, 480);

    // R2 divisor zero gives 16 clocks per bit
    bus_write(3'd2, 16'd0); bitc = 16;
    push_tx(9'h07E, 8, 0, 0, 1);
    wait_tx();
    bus_write(3'd2, 16'd2); bitc = 48;

    // R7 reception
    send_rx(9'h03C, 8, 0, 0, 0, 0);
    bus_read(3'd4, rd);
    check(rd[0] == 1'b1, "R7 ready set", int'(rd), 1);
    bus_read(3'd0, rd);
    check(rd == 16'h003C, "R7 data", int'(rd), 16'h3C);
    bus_read(3'd4, rd);
    check(rd[0] == 1'b0, "R7 ready cleared", int'(rd[0]), 0);

    // R8 parity error, sticky until status read
    bus_write(3'd1, 16'h000B);
    send_rx(9'h05B, 8, 1, 0, 1, 0);
    bus_read(3'd0, rd);
    bus_read(3'd4, rd);
    check((rd & 16'h0008) != 0, "R8 parity error", int'(rd), 16'h0008);
    bus_read(3'd4, rd);
    check((rd & 16'h0038) == 0, "R8 flags cleared", int'(rd), 0);
    send_rx(9'h05B, 8, 1, 0, 0, 0);
    bus_read(3'd0, rd);
    check(rd == 16'h005B, "R8 good parity data", int'(rd), 16'h5B);
    bus_read(3'd4, rd);
    check((rd & 16'h0008) == 0, "R8 no false parity", int'(rd), 0);

    // R8 framing error
    bus_write(3'd1, 16'h0003);
    send_rx(9'h022, 8, 0, 0, 0, 1);
    bus_read(3'd0, rd);
    bus_read(3'd4, rd);
    check((rd & 16'h0010) != 0, "R8 framing error", int'(rd), 16'h0010);

    // R9 overrun
    send_rx(9'h041, 8, 0, 0, 0, 0);
    send_rx(9'h042, 8, 0, 0, 0, 0);
    bus_read(3'd4, rd);
    check((rd & 16'h0021) == 16'h0021, "R9 overrun flag", int'(rd), 16'h21);
    bus_read(3'd0, rd);
    check(rd == 16'h0041, "R9 first kept", int'(rd), 16'h41);

    // R12 interrupts
    bus_write(3'd3, 16'd0);
    @(negedge clk);
    check(irq_tx == 1'b0, "R12 tx masked", int'(irq_tx), 0);
    bus_write(3'd3, 16'd1);
    @(negedge clk);
    check(irq_tx == 1'b1, "R12 tx enabled", int'(irq_tx), 1);
    send_rx(9'h010, 8, 0, 0, 0, 0);
    check(irq_rx == 1'b0, "R12 rx masked", int'(irq_rx), 0);
    bus_write(3'd3, 16'd3);
    @(negedge clk);
    check(irq_rx == 1'b1, "R12 rx enabled", int'(irq_rx), 1);
    bus_read(3'd0, rd);
    @(negedge clk);
    check(irq_rx == 1'b0, "R12 rx after read", int'(irq_rx), 0);
    bus_write(3'd3, 16'd0);

    // R10 nine-bit transmit
    bus_write(3'd1, 16'h0020);
    push_tx(9'h1C5, 9, 0, 0, 1);
    wait_tx();

    // R11 address filtering
    bus_write(3'd5, 16'h0012);
    bus_write(3'd1, 16'h0020);
    send_rx(9'h055, 9, 0, 0, 0, 0);
    bus_read(3'd4, rd);
    check(rd[0] == 1'b0, "R11 data dropped while waiting", int'(rd[0]), 0);
    send_rx(9'h134, 9, 0, 0, 0, 0);
    bus_read(3'd4, rd);
    check(rd[0] == 1'b0, "R11 foreign address dropped", int'(rd[0]), 0);
    send_rx(9'h112, 9, 0, 0, 0, 0);
    bus_read(3'd0, rd);
    check(rd == 16'h0112, "R11 own address delivered", int'(rd), 16'h112);
    send_rx(9'h066, 9, 0, 0, 0, 0);
    bus_read(3'd0, rd);
    check(rd == 16'h0066, "R11 data after match", int'(rd), 16'h66);
    send_rx(9'h134, 9, 0, 0, 0, 0);
    send_rx(9'h077, 9, 0, 0, 0, 0);
    bus_read(3'd4, rd);
    check(rd[0] == 1'b0, "R11 rewait after foreign address", int'(rd[0]), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule